// File: doc/BRIEF.md
# I2C Bus Clock and Data-Hold Timing Generator

This block produces the serial clock for an I2C master from the system clock, together with a strobe that marks when the data line may change after each clock falling edge. A 6-bit divider code selects the timing. The code is split into two 3-bit indices. Each index reads a small table of divider parameters. From these parameters the block computes the full clock period and the data hold time, both counted in system clocks.

A controller sets the divider code and raises the run request. On that start the generator latches the period and the hold for the code that is present. It then drives the clock high for half a period and low for half a period, and repeats for as long as run stays high. A strobe marks each falling edge. A second strobe fires a fixed hold time after each falling edge, and the byte engine uses it to change the data line. When run is dropped, the generator finishes the period in progress and returns to idle with the clock high. Clearing the enable stops everything at once.

Top module: `scl_timing_gen`

## Requirements
- R1: Index A is code bits {4,3,2}, with bit 2 as the least significant bit. Index A values 0 to 7 select the pair (edge_base, step) from the list (4,1), (4,2), (6,4), (6,8), (14,16), (30,32), (62,64), (126,128).
- R2: Index B is code bits {5,1,0}, with bit 0 as the least significant bit and bit 5 as the most significant bit. Index B values 0 to 7 select the pair (clk_taps, data_taps) from the list (9,3), (10,3), (12,4), (15,4), (5,1), (6,1), (7,2), (8,2).
- R3: The clock period is 2 × (edge_base + (clk_taps − 1) × step + 2) system clocks. The clock is low for exactly half a period and high for exactly half a period. Examples: code 0x00 gives a period of 28 and code 0x3F gives a period of 2048.
- R4: The data-change strobe is a one-cycle pulse. It rises exactly edge_base + (data_taps − 1) × step + 3 cycles after each falling-edge strobe, and it fires exactly once per period. Examples: code 0x00 gives 9 and code 0x3F gives 257.
- R5: The falling-edge strobe is a one-cycle pulse. It is high in the same cycle that the clock output first reads low.
- R6: After reset the clock output is high and both strobes are low.
- R7: The period and the hold are latched only when the generator leaves idle. A change of code while the generator runs has no effect until the next start.
- R8: If run is low when a low phase ends, the generator drives the clock high and stays idle. It produces no further strobes.
- R9: While enable is low, from the next cycle on the clock output is high and both strobes are low. Any pending data-change strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Generator enable |
| div_code | input | 6 | Divider code |
| run | input | 1 | Run request; a start is taken from idle |
| scl_o | output | 1 | Internal bus clock level |
| scl_fall_o | output | 1 | Falling-edge strobe |
| sda_chg_o | output | 1 | Data-change strobe |

## Verification
The codes 0x00 and 0x3F fix the two ends of the range. Codes that set only one index bit (0x01, 0x04, 0x10, 0x20) separate index A from index B. They would catch a wrong bit order or a swapped index, because any such error moves the measured period and hold away from the values the formulas predict. Code 0x1C, which sets all of index A with index B at zero, checks the upper table entries on their own. Separate scenarios change the code mid-run, drop run during a high phase, and pull enable low while a data strobe is pending; these show whether the latched timing, the orderly stop and the immediate stop behave as required.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 3;
  localparam int TAB_W  = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;

  typedef struct packed {
    logic [TAB_W-1:0] base;
    logic [TAB_W-1:0] step;
  } a_entry_t;

  typedef struct packed {
    logic [TAB_W-1:0] clk_taps;
    logic [TAB_W-1:0] dat_taps;
  } b_entry_t;

  // Index A table: edge offset and tap-to-tap step
  function automatic a_entry_t a_lookup(input logic [IDX_W-1:0] idx);
    a_entry_t e;
    case (idx)
      3'd0:    e = '{base: 8'd4,   step: 8'd1};
      3'd1:    e = '{base: 8'd4,   step: 8'd2};
      3'd2:    e = '{base: 8'd6,   step: 8'd4};
      3'd3:    e = '{base: 8'd6,   step: 8'd8};
      3'd4:    e = '{base: 8'd14,  step: 8'd16};
      3'd5:    e = '{base: 8'd30,  step: 8'd32};
      3'd6:    e = '{base: 8'd62,  step: 8'd64};
      default: e = '{base: 8'd126, step: 8'd128};
    endcase
    return e;
  endfunction

  // Index B table: clock tap count and data tap count
  function automatic b_entry_t b_lookup(input logic [IDX_W-1:0] idx);
    b_entry_t e;
    case (idx)
      3'd0:    e = '{clk_taps: 8'd9,  dat_taps: 8'd3};
      3'd1:    e = '{clk_taps: 8'd10, dat_taps: 8'd3};
      3'd2:    e = '{clk_taps: 8'd12, dat_taps: 8'd4};
      3'd3:    e = '{clk_taps: 8'd15, dat_taps: 8'd4};
      3'd4:    e = '{clk_taps: 8'd5,  dat_taps: 8'd1};
      3'd5:    e = '{clk_taps: 8'd6,  dat_taps: 8'd1};
      3'd6:    e = '{clk_taps: 8'd7,  dat_taps: 8'd2};
      default: e = '{clk_taps: 8'd8,  dat_taps: 8'd2};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode
  import scl_tim_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int HOLD_W = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [HALF_W-1:0] half_len,
  output logic [HOLD_W-1:0] hold_len
);
  logic [IDX_W-1:0] idx_a;
  logic [IDX_W-1:0] idx_b;
  a_entry_t ea;
  b_entry_t eb;
  int unsigned half_i;
  int unsigned hold_i;

  // R1 / R2: the scrambled bit groups
  assign idx_a = code[4:2];
  assign idx_b = {code[5], code[1], code[0]};

  always_comb begin
    ea     = a_lookup(idx_a);
    eb     = b_lookup(idx_b);
    half_i = 32'(ea.base) + (32'(eb.clk_taps) - 32'd1) * 32'(ea.step) + 32'd2;
    hold_i = 32'(ea.base) + (32'(eb.dat_taps) - 32'd1) * 32'(ea.step) + 32'd3;
    half_len = HALF_W'(half_i);
    hold_len = HOLD_W'(hold_i);
  end

  // R4: the hold must end inside the low half-period
  always_comb begin
    assert_hold_inside_low_R4: assert (32'(hold_len) < 32'(half_len));
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_tim_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int HOLD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              run,
  input  logic [HALF_W-1:0] half_in,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              scl,
  output logic              fall_stb,
  output logic [HOLD_W-1:0] hold_q
);
  localparam logic [HALF_W-1:0] ONE_H = HALF_W'(1);

  phase_t            st_q;
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;
  logic              last_cnt;

  assign last_cnt = (cnt_q == half_q - ONE_H);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PH_IDLE;
      cnt_q    <= '0;
      half_q   <= '0;
      hold_q   <= '0;
      scl      <= 1'b1;
      fall_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      if (!enable) begin
        st_q  <= PH_IDLE;
        cnt_q <= '0;
        scl   <= 1'b1;
      end else begin
        case (st_q)
          PH_IDLE: begin
            scl <= 1'b1;
            if (run) begin
              half_q <= half_in;   // R7: latched only here
              hold_q <= hold_in;
              cnt_q  <= '0;
              st_q   <= PH_HIGH;
            end
          end
          PH_HIGH: begin
            if (last_cnt) begin
              st_q     <= PH_LOW;
              cnt_q    <= '0;
              scl      <= 1'b0;
              fall_stb <= 1'b1;
            end else begin
              cnt_q <= cnt_q + ONE_H;
            end
          end
          PH_LOW: begin
            if (last_cnt) begin
              cnt_q <= '0;
              scl   <= 1'b1;
              st_q  <= run ? PH_HIGH : PH_IDLE;  // R8
            end else begin
              cnt_q <= cnt_q + ONE_H;
            end
          end
          default: begin
            st_q <= PH_IDLE;
            scl  <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_fall_marks_drop_R5: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (!scl && $past(scl)));

  assert_fall_single_R5: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !fall_stb);

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl && !fall_stb));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q != PH_IDLE) |=> (st_q == PH_IDLE || $stable(half_q)));
endmodule

// File: rtl/sda_hold_gen.sv
module sda_hold_gen #(
  parameter int HOLD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fall_stb,
  input  logic [HOLD_W-1:0] hold_q,
  output logic              sda_stb
);
  localparam logic [HOLD_W-1:0] ONE_D = HOLD_W'(1);

  logic              active_q;
  logic [HOLD_W-1:0] hcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
      sda_stb  <= 1'b0;
    end else begin
      sda_stb <= 1'b0;
      if (fall_stb) begin
        active_q <= 1'b1;
        hcnt_q   <= ONE_D;
      end else if (active_q) begin
        if (hcnt_q == hold_q - ONE_D) begin
          sda_stb  <= 1'b1;
          active_q <= 1'b0;
        end else begin
          hcnt_q <= hcnt_q + ONE_D;
        end
      end
    end
  end

  assert_hcnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (hcnt_q < hold_q));

  assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (rst)
    sda_stb |-> !fall_stb);

  assert_sda_off_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sda_stb);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tim_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int HOLD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CODE_W-1:0] div_code,
  input  logic              run,
  output logic              scl_o,
  output logic              scl_fall_o,
  output logic              sda_chg_o
);
  logic [HALF_W-1:0] half_len;
  logic [HOLD_W-1:0] hold_len;
  logic [HOLD_W-1:0] hold_lat;

  scl_div_decode #(.HALF_W(HALF_W), .HOLD_W(HOLD_W)) u_dec (
    .code     (div_code),
    .half_len (half_len),
    .hold_len (hold_len)
  );

  scl_phase_gen #(.HALF_W(HALF_W), .HOLD_W(HOLD_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .run      (run),
    .half_in  (half_len),
    .hold_in  (hold_len),
    .scl      (scl_o),
    .fall_stb (scl_fall_o),
    .hold_q   (hold_lat)
  );

  sda_hold_gen #(.HOLD_W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .fall_stb (scl_fall_o),
    .hold_q   (hold_lat),
    .sda_stb  (sda_chg_o)
  );

  assert_reset_state_R6: assert property (@(posedge clk)
    rst |=> (scl_o && !scl_fall_o && !sda_chg_o));
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [5:0] div_code = 6'h00;
  logic       run = 1'b0;
  logic       scl_o, scl_fall_o, sda_chg_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  scl_timing_gen u0 (
    .clk(clk), .rst(rst), .enable(enable), .div_code(div_code), .run(run),
    .scl_o(scl_o), .scl_fall_o(scl_fall_o), .sda_chg_o(sda_chg_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected timing computed from the requirement formulas
  function automatic int tab_a(input int i, input bit want_step);
    int b[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    int s[8] = '{1, 2, 4, 8, 16, 32, 64, 128};
    return want_step ? s[i] : b[i];
  endfunction
  function automatic int tab_b(input int i, input bit want_dat);
    int c[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
    int d[8] = '{3, 3, 4, 4, 1, 1, 2, 2};
    return want_dat ? d[i] : c[i];
  endfunction
  function automatic int exp_half(input logic [5:0] c);
    int ia = int'(c[4:2]);
    int ib = int'({c[5], c[1], c[0]});
    return tab_a(ia, 0) + (tab_b(ib, 0) - 1) * tab_a(ia, 1) + 2;
  endfunction
  function automatic int exp_hold(input logic [5:0] c);
    int ia = int'(c[4:2]);
    int ib = int'({c[5], c[1], c[0]});
    return tab_a(ia, 0) + (tab_b(ib, 1) - 1) * tab_a(ia, 1) + 3;
  endfunction

  task automatic wait_idle(input int n);
    run = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Runs one code for three falling edges and checks period, halves and hold
  task automatic t_code(input logic [5:0] code, input string req);
    int h = exp_half(code);
    int d = exp_hold(code);
    int cyc = 0, nf = 0, ns = 0, s0 = -1, lowlen = 0;
    int f[3];
    bit seen_hi = 0;
    @(negedge clk);
    div_code = code;
    run = 1'b1;
    while (nf < 3 && cyc < 8000) begin
      @(negedge clk);
      cyc++;
      if (scl_fall_o) begin
        f[nf] = cyc;
        nf++;
      end
      if (nf == 1) begin
        if (!scl_o && !seen_hi) lowlen++;
        if (scl_o) seen_hi = 1;
        if (sda_chg_o) begin
          ns++;
          if (s0 < 0) s0 = cyc;
        end
      end
    end
    chk(nf == 3, {req, " falls seen"}, nf, 3);
    if (nf == 3) begin
      chk(f[1] - f[0] == 2 * h, {req, " R3 period"}, f[1] - f[0], 2 * h);
      chk(f[2] - f[1] == 2 * h, {req, " R3 period repeat"}, f[2] - f[1], 2 * h);
      chk(lowlen == h, {req, " R3 low half"}, lowlen, h);
      chk(f[1] - f[0] - lowlen == h, {req, " R3 high half"}, f[1] - f[0] - lowlen, h);
      chk(s0 - f[0] == d, {req, " R4 hold"}, s0 - f[0], d);
      chk(ns == 1, {req, " R4 one strobe per period"}, ns, 1);
    end
    wait_idle(2 * h + 4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(scl_o == 1'b1, "R6 scl high after reset", int'(scl_o), 1);
    chk(!scl_fall_o && !sda_chg_o, "R6 strobes low after reset",
        int'(scl_fall_o) + int'(sda_chg_o), 0);
  endtask

  task automatic t_pulse_shape();
    int bad = 0;
    logic prev_scl = 1'b1, prev_fall = 1'b0;
    @(negedge clk);
    div_code = 6'h00;
    run = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (scl_fall_o && !(prev_scl && !scl_o)) bad++;
      if (!scl_fall_o && prev_scl && !scl_o) bad++;
      if (scl_fall_o && prev_fall) bad++;
      prev_scl = scl_o;
      prev_fall = scl_fall_o;
    end
    chk(bad == 0, "R5 fall strobe single and aligned", bad, 0);
    wait_idle(40);
  endtask

  task automatic t_mid_change();
    int cyc = 0, nf = 0;
    int f[3];
    @(negedge clk);
    div_code = 6'h00;
    run = 1'b1;
    while (nf < 3 && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (scl_fall_o) begin
        f[nf] = cyc;
        nf++;
        if (nf == 1) div_code = 6'h3F;
      end
    end
    chk(nf == 3 && f[1] - f[0] == 28, "R7 code change ignored mid-run", f[1] - f[0], 28);
    chk(nf == 3 && f[2] - f[1] == 28, "R7 code change ignored later", f[2] - f[1], 28);
    wait_idle(40);
    t_code(6'h3F, "R7 new code at next start");
  endtask

  task automatic t_stop();
    int cyc = 0, nfall = 0, rise_at = -1, fall_at = -1, extra = 0;
    @(negedge clk);
    div_code = 6'h00;
    run = 1'b1;
    while (!scl_fall_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    for (int i = 0; i < 20; i++) @(negedge clk);  // now in high phase
    run = 1'b0;
    cyc = 0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (scl_fall_o) begin
        nfall++;
        fall_at = cyc;
      end
      if (fall_at > 0 && rise_at < 0 && scl_o) rise_at = cyc;
      if (rise_at > 0 && (!scl_o || scl_fall_o || sda_chg_o)) extra++;
    end
    chk(nfall == 1, "R8 one final falling edge", nfall, 1);
    chk(rise_at - fall_at == 14, "R8 final low half completed", rise_at - fall_at, 14);
    chk(extra == 0, "R8 idle high with no strobes", extra, 0);
  endtask

  task automatic t_disable();
    int cyc = 0, bad = 0;
    @(negedge clk);
    div_code = 6'h10;   // hold 49, gives a wide pending window
    run = 1'b1;
    while (!scl_fall_o && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    for (int i = 0; i < 10; i++) @(negedge clk);  // data strobe pending
    enable = 1'b0;
    @(negedge clk);
    chk(scl_o && !scl_fall_o && !sda_chg_o, "R9 quiet next cycle",
        int'(scl_o), 1);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!scl_o || scl_fall_o || sda_chg_o) bad++;
    end
    chk(bad == 0, "R9 stays quiet with run high", bad, 0);
    enable = 1'b1;
    wait_idle(4);
    t_code(6'h10, "R9 restart after enable");
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    enable = 1'b1;
    t_code(6'h00, "R1 R2 code 00");
    t_code(6'h3F, "R1 R2 code 3F");
    t_code(6'h01, "R2 bit0");
    t_code(6'h20, "R2 bit5");
    t_code(6'h04, "R1 bit2");
    t_code(6'h10, "R1 bit4");
    t_code(6'h1C, "R1 index A max");
    t_pulse_shape();
    t_mid_change();
    t_stop();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule